// File: doc/BRIEF.md
# Edge-Event GPIO Port

A general-purpose I/O block for a configurable number of pins (16 by default), reached over a plain register bus with separate read and write strobes. Software sets each pin's direction, drives levels on output pins and reads back the pin levels through a two-stage synchronizer. A control bit gates the input sampler: while it is clear the sampled inputs hold and no events are detected.

One programmable event source watches a single chosen pin for a chosen edge and raises a pending flag. A second source is an external keypad request line. Both sources share a status register and a mask register, and a registered interrupt line signals any unmasked pending source. The event flag clears when software reads the status register, and an edge arriving in the same cycle as that read still leaves the flag set.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction register (address 2) reads 0xFFFF, the mask register (address 6) reads 0x0003, the output register reads 0x0000, `pad_oe` is all zeros and `irq` is low.
- R2: Direction bit 1 makes the pin an input and 0 an output; `pad_oe` equals the bitwise inverse of the direction register from the cycle after the write.
- R3: `pad_out` equals the output register (address 1) from the cycle after the write, and a read of address 1 returns the written value.
- R4: A read of address 0 returns the pin levels after a two-flop synchronizer; while control bit 5 (address 3) is 0 the sampled value holds and no event is detected.
- R5: Event register (address 4): bit 0 enables, bits 4:1 select the pin, bit 5 picks the edge (1 rising, 0 falling); only that edge on that pin sets status bit 1.
- R6: Status (address 5) bit 0 follows the keypad request and is not cleared by a read; bit 1 clears when the status register is read.
- R7: An event edge detected in the same cycle as a status read leaves status bit 1 set after that read.
- R8: Mask bit 1 masks a source (bit 0 keypad, bit 1 event); `irq` is the OR of unmasked pending status bits, registered one cycle after the status.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is 0 otherwise; writes to addresses 0 and 5 have no effect and unmapped address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pin input levels |
| pad_out | output | 16 | Pin output levels |
| pad_oe | output | 16 | Pin output enables, 1 = driven |
| kbd_req | input | 1 | Keypad interrupt request level |
| irq | output | 1 | Combined interrupt |

## Verification
The event detector setting the GPIO status bit and a status read clearing it can land in the same cycle. The bench provokes this by holding a continuous status read across the whole window in which a selected pin edge propagates through the synchronizer, so one of those reads must coincide with the detection. It then counts how many of the returned values carry the event bit: exactly one is correct, while zero shows the edge was lost to the clear.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PIN  = 3'd0,
    RA_DOUT = 3'd1,
    RA_DIR  = 3'd2,
    RA_CTL  = 3'd3,
    RA_EVT  = 3'd4,
    RA_STAT = 3'd5,
    RA_MASK = 3'd6
  } reg_addr_e;

  localparam int SRC_KBD = 0;
  localparam int SRC_EVT = 1;
  localparam int NSRC    = 2;
endpackage

// File: rtl/gpio_sync_sampler.sv
module gpio_sync_sampler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] s_new,
  output logic [W-1:0] s_old,
  output logic         pair_ok
);
  logic v0_q, v1_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic m1_q, m2_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          m1_q <= 1'b0;
          m2_q <= 1'b0;
        end else if (ce) begin
          m1_q <= pad_in[i];
          m2_q <= m1_q;
        end
      end
      assign s_new[i] = m1_q;
      assign s_old[i] = m2_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q <= 1'b0;
      v1_q <= 1'b0;
    end else begin
      v0_q <= ce;
      v1_q <= ce & v0_q;
    end
  end

  assign pair_ok = v1_q;
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt #(
  parameter int W  = 16,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift,
  input  logic          pair_ok,
  input  logic [W-1:0]  s_new,
  input  logic [W-1:0]  s_old,
  input  logic          evt_en,
  input  logic [PW-1:0] evt_pin,
  input  logic          evt_rise,
  input  logic          clr,
  output logic          pend
);
  logic nb, ob, hit;

  always_comb begin
    nb  = s_new[evt_pin];
    ob  = s_old[evt_pin];
    hit = shift & pair_ok & evt_en & (evt_rise ? (nb & ~ob) : (~nb & ob));
  end

  // A fresh edge outranks the clear from a concurrent status read.
  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (hit) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kbd_req,
  input  logic          evt_pend,
  input  logic [NS-1:0] mask,
  output logic [NS-1:0] status,
  output logic          irq
);
  logic kbd_q;

  always_ff @(posedge clk) begin
    if (rst) kbd_q <= 1'b0;
    else     kbd_q <= kbd_req;
  end

  always_comb begin
    status    = '0;
    status[0] = kbd_q;
    status[1] = evt_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ~mask);
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DW     = 16,
  parameter int CE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic              kbd_req,
  output logic              irq
);
  localparam int PW    = $clog2(PINS);
  localparam int EVT_W = PW + 2;

  logic [PINS-1:0]  dout_q, dir_q;
  logic             ce_q;
  logic [EVT_W-1:0] evt_q;
  logic [NSRC-1:0]  mask_q;
  logic [PINS-1:0]  samp_new, samp_old;
  logic             pair_ok, evt_pend, stat_rd;
  logic [NSRC-1:0]  status;
  logic [DW-1:0]    rd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '1;
      ce_q   <= 1'b0;
      evt_q  <= '0;
      mask_q <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        RA_DOUT: dout_q <= bus_wdata[PINS-1:0];
        RA_DIR:  dir_q  <= bus_wdata[PINS-1:0];
        RA_CTL:  ce_q   <= bus_wdata[CE_BIT];
        RA_EVT:  evt_q  <= bus_wdata[EVT_W-1:0];
        RA_MASK: mask_q <= bus_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  gpio_sync_sampler #(.W(PINS)) u_samp (
    .clk(clk), .rst(rst), .ce(ce_q), .pad_in(pad_in),
    .s_new(samp_new), .s_old(samp_old), .pair_ok(pair_ok)
  );

  assign stat_rd = bus_rd && (bus_addr == RA_STAT);

  gpio_edge_evt #(.W(PINS), .PW(PW)) u_evt (
    .clk(clk), .rst(rst), .shift(ce_q), .pair_ok(pair_ok),
    .s_new(samp_new), .s_old(samp_old),
    .evt_en(evt_q[0]), .evt_pin(evt_q[PW:1]), .evt_rise(evt_q[PW+1]),
    .clr(stat_rd), .pend(evt_pend)
  );

  gpio_irq_ctl #(.NS(NSRC)) u_irq (
    .clk(clk), .rst(rst), .kbd_req(kbd_req), .evt_pend(evt_pend),
    .mask(mask_q), .status(status), .irq(irq)
  );

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      RA_PIN:  rd_val[PINS-1:0]  = samp_old;
      RA_DOUT: rd_val[PINS-1:0]  = dout_q;
      RA_DIR:  rd_val[PINS-1:0]  = dir_q;
      RA_CTL:  rd_val[CE_BIT]    = ce_q;
      RA_EVT:  rd_val[EVT_W-1:0] = evt_q;
      RA_STAT: rd_val[NSRC-1:0]  = status;
      RA_MASK: rd_val[NSRC-1:0]  = mask_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  assign pad_out = dout_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int PINS = 16,
  parameter int DW   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic              irq,
  input logic              ce,
  input logic [PINS-1:0]   samp,
  input logic              evt_pend,
  input logic [NSRC-1:0]   mask
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && !irq && mask == '1));

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_DIR) |=> (pad_oe == ~$past(bus_wdata[PINS-1:0])));

  p_dout_pad_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_DOUT) |=> (pad_out == $past(bus_wdata[PINS-1:0])));

  p_sample_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(samp));

  p_no_event_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!ce && !evt_pend) |=> !evt_pend);

  p_pend_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_pend && !(bus_rd && bus_addr == RA_STAT)) |=> evt_pend);

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !irq);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PINS(PINS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .ce(ce_q), .samp(samp_old),
  .evt_pend(evt_pend), .mask(mask_q)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        kbd_req = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit model_on = 0;

  always #10 clk = ~clk;

  gpio_edge_port uut (.*);

  // behavioural reference, advanced on every rising edge
  int m_s1, m_s2, m_v0, m_v1, m_dout, m_dir, m_ce, m_evt, m_mask;
  int m_sk, m_sg, m_irq, m_rdata;
  always @(posedge clk) begin
    int rv, p, hit, st;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_v0 = 0; m_v1 = 0; m_dout = 0; m_dir = 'hFFFF;
      m_ce = 0; m_evt = 0; m_mask = 3; m_sk = 0; m_sg = 0; m_irq = 0; m_rdata = 0;
    end else begin
      st = m_sg * 2 + m_sk;
      rv = 0;
      if (bus_rd) case (bus_addr)
        0: rv = m_s2;   1: rv = m_dout; 2: rv = m_dir;
        3: rv = m_ce * 32; 4: rv = m_evt; 5: rv = st; 6: rv = m_mask;
        default: rv = 0;
      endcase
      p = (m_evt >> 1) & 15;
      hit = 0;
      if (m_ce && m_v1 && (m_evt & 1)) begin
        if (m_evt & 32) hit = ((m_s1 >> p) & 1) && !((m_s2 >> p) & 1);
        else            hit = !((m_s1 >> p) & 1) && ((m_s2 >> p) & 1);
      end
      m_irq = ((st & ~m_mask & 3) != 0);
      if (hit) m_sg = 1;
      else if (bus_rd && bus_addr == 5) m_sg = 0;
      m_sk = kbd_req;
      m_v1 = m_ce && m_v0;
      m_v0 = m_ce;
      if (m_ce) begin m_s2 = m_s1; m_s1 = pad_in; end
      m_rdata = rv;
      if (bus_wr) case (bus_addr)
        1: m_dout = bus_wdata; 2: m_dir = bus_wdata;
        3: m_ce = bus_wdata[5]; 4: m_evt = bus_wdata[5:0];
        6: m_mask = bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on && !rst) begin
    chk({tag, " model rdata"}, bus_rdata, m_rdata);
    chk({tag, " model pad_out"}, pad_out, m_dout);
    chk({tag, " model pad_oe"}, pad_oe, ~m_dir & 'hFFFF);
    chk({tag, " model irq"}, irq, m_irq);
  end

  task automatic wr(input int a, input int d);
    bus_addr = a[2:0]; bus_wdata = d[15:0]; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = a[2:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1;
    tag = "R1";
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", irq, 0);
    rd(2, d); chk("R1 dir", d, 'hFFFF);
    rd(6, d); chk("R1 mask", d, 'h0003);
    rd(1, d); chk("R1 dout", d, 0);

    tag = "R2";
    wr(2, 'h00F0); chk("R2 pad_oe", pad_oe, 'hFF0F);
    tag = "R3";
    wr(1, 'hA5A5); chk("R3 pad_out", pad_out, 'hA5A5);
    rd(1, d); chk("R3 readback", d, 'hA5A5);

    tag = "R4";
    pad_in = 'h1234; idle(4);
    rd(0, d); chk("R4 gated input", d, 0);
    wr(3, 'h0020); idle(3);
    rd(0, d); chk("R4 synced input", d, 'h1234);
    rd(3, d); chk("R4 ctl readback", d, 'h0020);

    tag = "R5";
    wr(4, 'h0027);                 // rising, pin 3
    pad_in = 'h123C; idle(4);
    rd(5, d); chk("R5 rising pin3", d, 2);
    tag = "R6";
    rd(5, d); chk("R6 cleared by read", d, 0);
    tag = "R5";
    pad_in = 'h1234; idle(4);
    rd(5, d); chk("R5 falling ignored", d, 0);
    pad_in = 'h12B4; idle(4);
    rd(5, d); chk("R5 other pin ignored", d, 0);
    wr(4, 'h0007);                 // falling, pin 3
    pad_in = 'h12BC; idle(4);
    rd(5, d); chk("R5 rising ignored", d, 0);
    pad_in = 'h12B4; idle(4);
    rd(5, d); chk("R5 falling pin3", d, 2);
    rd(5, d); chk("R6 falling cleared", d, 0);

    tag = "R6";
    kbd_req = 1'b1; idle(2);
    rd(5, d); chk("R6 kbd pending", d, 1);
    rd(5, d); chk("R6 kbd kept", d, 1);

    tag = "R8";
    chk("R8 masked irq", irq, 0);
    wr(6, 'h0002); idle(2);
    chk("R8 kbd unmasked irq", irq, 1);
    wr(6, 'h0003); idle(2);
    chk("R8 remasked irq", irq, 0);
    kbd_req = 1'b0;
    wr(6, 'h0001);

    tag = "R7";
    wr(4, 'h0027); idle(2);
    pad_in = 'h12BC;
    bus_addr = 3'd5; bus_rd = 1'b1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_rdata[1]) hits++;
    end
    bus_rd = 1'b0;
    chk("R7 edge during read kept", hits, 1);
    idle(2);
    chk("R8 event unmasked irq", irq, 0);
    pad_in = 'h12B4; idle(1);
    pad_in = 'h12BC; idle(4);
    chk("R8 event unmasked irq", irq, 1);

    tag = "R9";
    wr(5, 'hFFFF);
    rd(5, d); chk("R9 status write ignored", d, 2);
    wr(0, 'hFFFF);
    rd(0, d); chk("R9 input write ignored", d, 'h12BC);
    rd(7, d); chk("R9 unmapped", d, 0);
    idle(1); chk("R9 rdata idle", bus_rdata, 0);

    tag = "R4";
    wr(3, 0);
    pad_in = 'h0000; idle(4);
    rd(0, d); chk("R4 held while off", d, 'h12BC);
    rd(5, d); chk("R4 no event while off", d, 0);
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule